// File: doc/BRIEF.md
# Up/Down Reload Counter with Edge-Triggered Clear

This block is a 14-bit counter that acts as a small state machine. It counts up or down, one step per clock. When it reaches its end value it reloads itself from a configuration word `reload_val` and raises a pulse for one cycle. A hold input freezes the count. A load input jumps the count straight to its start value. A separate trigger input clears the count to zero on a chosen edge.

In up mode the end value is the all-ones count (16383 by default). After a reset or a clear, the count climbs from zero. Every later pass starts at `reload_val`, because the wrap goes to that value rather than to zero. In down mode the start value is `reload_val + 1`, taken modulo 2^WIDTH, and the count falls to zero. The low byte of the count is driven on a separate registered tap for compare logic further downstream.

Top module: `ucnt_reload_fsm`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released with `hold` high, `count` is 0, `tap` is 0 and `term_pulse` is 0.
- R2: In up mode (`dir_up`=1), with no clear, load or hold, and with `count` below 16383, `count` rises by exactly 1 per clock. After a reset the first pass therefore runs 0, 1, ..., 16383.
- R3: In up mode, a clock edge that finds `count` at 16383 sets `count` to `reload_val`. Every later pass therefore starts at `reload_val`.
- R4: In down mode (`dir_up`=0), `count` falls by 1 per clock. A clock edge that finds `count` at 0 sets `count` to `reload_val + 1` (modulo 2^14).
- R5: `term_pulse` is high in a cycle where `count` is at the end value (16383 in up mode, 0 in down mode) only if it was not at the end value in the previous cycle. It therefore lasts one cycle, even when `hold` keeps `count` at the end value.
- R6: With `hold`=1 and no clear or load, `count` keeps its value across the clock edge.
- R7: A clock edge with `load`=1 and no clear sets `count` to `reload_val` in up mode or to `reload_val + 1` in down mode. Load wins over `hold`.
- R8: `clr_mode` selects which edges of `clr_in` clear the count: 2'b00 = none, 2'b01 = rising, 2'b10 = falling, 2'b11 = both. An edge is a difference between `clr_in` and its value sampled at the previous clock. A selected edge sets `count` to 0 at that clock edge, ahead of load and hold. Edges that are not selected have no effect.
- R9: `tap` always equals bits [7:0] of `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| hold | input | 1 | Freeze the count |
| load | input | 1 | Synchronous jump to the start value |
| clr_in | input | 1 | Trigger input for the edge clear |
| clr_mode | input | 2 | Edge selection for `clr_in` |
| reload_val | input | 14 | Reload configuration word |
| count | output | 14 | Current count |
| tap | output | 8 | Registered low byte of the count |
| term_pulse | output | 1 | One-cycle end-of-count pulse |

## Verification
The assertions check the following on every cycle: the single-step up count, the stable count under hold, the load target, the clear to zero after a detected edge, the one-cycle width of the end pulse, and the tap tracking the count. The bench scenarios are needed for the rest. They show that the first up pass starts from zero and later passes start from the reload value. They run the down-mode reload to `reload_val + 1`. They show that unselected edges leave the count alone in each edge mode, and that the priority of clear over load over hold holds at the ports.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
   typedef enum logic [1:0] {
      CLR_OFF  = 2'b00,
      CLR_RISE = 2'b01,
      CLR_FALL = 2'b10,
      CLR_BOTH = 2'b11
   } clr_edge_e;
endpackage

// File: rtl/ucnt_edge_det.sv
module ucnt_edge_det
   import ucnt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sig_in,
   input  logic [1:0] mode,
   output logic       evt
);
   logic      prev_q;
   logic      rise_w;
   logic      fall_w;
   clr_edge_e mode_e;

   assign mode_e = clr_edge_e'(mode);
   assign rise_w = sig_in & ~prev_q;
   assign fall_w = ~sig_in & prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_in;
   end

   always_comb begin
      unique case (mode_e)
         CLR_RISE: evt = rise_w;
         CLR_FALL: evt = fall_w;
         CLR_BOTH: evt = rise_w | fall_w;
         default:  evt = 1'b0;
      endcase
   end

   // R8: an off mode never produces a clear event
   a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> !evt);
endmodule

// File: rtl/ucnt_next.sv
module ucnt_next #(
   parameter int WIDTH = 14
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             dir_up,
   input  logic             hold,
   input  logic             load,
   input  logic             clr,
   input  logic [WIDTH-1:0] reload_val,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ZERO = '0;

   logic [WIDTH-1:0] start_w;
   logic             at_end_w;

   assign start_w  = dir_up ? reload_val : reload_val + 1'b1;
   assign at_end_w = dir_up ? (cur == TOP) : (cur == ZERO);

   always_comb begin
      if (clr)           nxt = ZERO;
      else if (load)     nxt = start_w;
      else if (hold)     nxt = cur;
      else if (at_end_w) nxt = start_w;
      else if (dir_up)   nxt = cur + 1'b1;
      else               nxt = cur - 1'b1;
   end
endmodule

// File: rtl/ucnt_term.sv
module ucnt_term #(
   parameter int WIDTH = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur,
   input  logic             dir_up,
   output logic             pulse
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   logic at_end_w;
   logic was_end_q;

   assign at_end_w = dir_up ? (cur == TOP) : (cur == '0);
   assign pulse    = at_end_w & ~was_end_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) was_end_q <= 1'b1;
      else        was_end_q <= at_end_w;
   end

   // R5: the end pulse never lasts two cycles
   a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/ucnt_reload_fsm.sv
module ucnt_reload_fsm
   import ucnt_pkg::*;
#(
   parameter int WIDTH = 14,
   parameter int TAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_up,
   input  logic             hold,
   input  logic             load,
   input  logic             clr_in,
   input  logic [1:0]       clr_mode,
   input  logic [WIDTH-1:0] reload_val,
   output logic [WIDTH-1:0] count,
   output logic [TAP_W-1:0] tap,
   output logic             term_pulse
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2)      begin : g_bad_width $error("WIDTH must be at least 2"); end
      if (TAP_W < 1 || TAP_W > WIDTH) begin : g_bad_tap $error("TAP_W must lie in 1..WIDTH"); end
   endgenerate

   logic             clr_evt;
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_nxt;
   logic [TAP_W-1:0] tap_q;

   ucnt_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (clr_in),
      .mode   (clr_mode),
      .evt    (clr_evt)
   );

   ucnt_next #(.WIDTH(WIDTH)) u_next (
      .cur        (cnt_q),
      .dir_up     (dir_up),
      .hold       (hold),
      .load       (load),
      .clr        (clr_evt),
      .reload_val (reload_val),
      .nxt        (cnt_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tap_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
         tap_q <= cnt_nxt[TAP_W-1:0];
      end
   end

   ucnt_term #(.WIDTH(WIDTH)) u_term (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur    (cnt_q),
      .dir_up (dir_up),
      .pulse  (term_pulse)
   );

   assign count = cnt_q;
   assign tap   = tap_q;

   // R2: plain up step
   a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_up && !hold && !load && !clr_evt && cnt_q != TOP)
      |=> cnt_q == $past(cnt_q) + 1'b1);
   // R6: hold freezes the count
   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !load && !clr_evt) |=> cnt_q == $past(cnt_q));
   // R7: load target depends on direction
   a_r7_load_target: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr_evt) |=> cnt_q == ($past(dir_up) ? $past(reload_val)
                                                      : $past(reload_val) + 1'b1));
   // R8: a detected edge clears the count
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt |=> cnt_q == '0);
   // R9: tap follows the low bits
   a_r9_tap_match: assert property (@(posedge clk) disable iff (!rst_n)
      tap_q == cnt_q[TAP_W-1:0]);
endmodule

// File: tb/ucnt_reload_fsm_tb.sv
module ucnt_reload_fsm_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 14;
   localparam int TOPV = 16383;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         dir_up, hold, load, clr_in;
   logic [1:0]   clr_mode;
   logic [W-1:0] reload_val;
   logic [W-1:0] count;
   logic [7:0]   tap;
   logic         term_pulse;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ucnt_reload_fsm u_dut (
      .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .hold(hold), .load(load),
      .clr_in(clr_in), .clr_mode(clr_mode), .reload_val(reload_val),
      .count(count), .tap(tap), .term_pulse(term_pulse)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_cnt(string req, int exp);
      chk(req, int'(count), exp);
      chk({req, " R9 tap"}, int'(tap), exp & 255);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; dir_up = 1'b1; hold = 1'b1; load = 1'b0;
      clr_in = 1'b0; clr_mode = 2'b00; reload_val = 14'd100;
      #3;
      chk_cnt("R1 during reset", 0);
      chk("R1 term during reset", int'(term_pulse), 0);
      repeat (2) @(posedge clk);
      #2 rst_n = 1'b1;
      tick();
      chk_cnt("R1 after release", 0);
      chk("R1 term after release", int'(term_pulse), 0);
   endtask

   task automatic t_up_first_pass();
      int bad = 0;
      hold = 1'b0;
      for (int i = 1; i <= TOPV; i++) begin
         tick();
         if (int'(count) != i && bad == 0) bad = i;
      end
      chk("R2 first pass from zero (first bad step)", bad, 0);
      chk_cnt("R2 reached top", TOPV);
      chk("R5 pulse at top", int'(term_pulse), 1);
      tick();
      chk_cnt("R3 wrap to reload", 100);
      chk("R5 pulse gone", int'(term_pulse), 0);
      tick();
      chk_cnt("R3 second pass climbs", 101);
   endtask

   task automatic t_load_hold();
      reload_val = 14'd16381; load = 1'b1;
      tick();
      chk_cnt("R7 up load", 16381);
      load = 1'b0;
      tick(); chk_cnt("R2 step", 16382);
      chk("R5 no pulse below top", int'(term_pulse), 0);
      tick(); chk_cnt("R2 step to top", TOPV);
      chk("R5 pulse on entry", int'(term_pulse), 1);
      hold = 1'b1;
      tick(); chk_cnt("R6 hold at top", TOPV);
      chk("R5 no repeat while held", int'(term_pulse), 0);
      tick(); chk_cnt("R6 still held", TOPV);
      chk("R5 still no pulse", int'(term_pulse), 0);
      hold = 1'b0;
      tick(); chk_cnt("R3 reload after hold", 16381);
   endtask

   task automatic t_down();
      dir_up = 1'b0; reload_val = 14'd5; load = 1'b1;
      tick(); chk_cnt("R7 down load N+1", 6);
      load = 1'b0;
      for (int e = 5; e >= 1; e--) begin
         tick(); chk_cnt("R4 decrement", e);
      end
      tick(); chk_cnt("R4 reach zero", 0);
      chk("R5 pulse at zero", int'(term_pulse), 1);
      tick(); chk_cnt("R4 reload N+1", 6);
      chk("R5 pulse dropped", int'(term_pulse), 0);
   endtask

   task automatic t_priority();
      dir_up = 1'b1; reload_val = 14'd40; load = 1'b1; hold = 1'b1;
      tick(); chk_cnt("R7 load beats hold", 40);
      load = 1'b0;
      tick(); chk_cnt("R6 hold", 40);
      hold = 1'b0; clr_mode = 2'b01; load = 1'b1; clr_in = 1'b1;
      tick(); chk_cnt("R8 clear beats load", 0);
      load = 1'b0;
      tick(); chk_cnt("R8 level not an edge", 1);
   endtask

   task automatic t_edges();
      clr_in = 1'b0;
      tick(); chk_cnt("R8 fall ignored in rise mode", 2);
      clr_mode = 2'b10; clr_in = 1'b1;
      tick(); chk_cnt("R8 rise ignored in fall mode", 3);
      clr_in = 1'b0;
      tick(); chk_cnt("R8 fall clears", 0);
      tick(); chk_cnt("R8 counts on", 1);
      clr_mode = 2'b11; clr_in = 1'b1;
      tick(); chk_cnt("R8 both mode rise", 0);
      tick(); chk_cnt("R8 counts on", 1);
      clr_in = 1'b0;
      tick(); chk_cnt("R8 both mode fall", 0);
      clr_mode = 2'b00; clr_in = 1'b1;
      tick(); chk_cnt("R8 off mode rise ignored", 1);
      clr_in = 1'b0;
      tick(); chk_cnt("R8 off mode fall ignored", 2);
   endtask

   initial begin
      t_reset();
      t_up_first_pass();
      t_load_hold();
      t_down();
      t_priority();
      t_edges();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule